// File: doc/BRIEF.md
# Gated Serial Device Clock Generator

This block derives a serial-peripheral clock from the system clock and frames it with an active-low chip select. A controller sets the half-period through a divider input and may change it at any time. The block applies a new rate only between transactions, so the link can be brought up slowly and then run faster without a shortened pulse. A transaction is requested with a start pulse and a bit count. The block pulls chip select low and waits one idle device-clock period. It then produces one clock pulse per bit, waits two idle periods with the clock low, and releases chip select.

The device clock idles low, in SPI mode 0 style. Each rising edge and each falling edge of the device clock comes with a one-cycle strobe in the same system clock as the edge. A neighbouring data path uses these strobes to sample on rises and shift on falls. Busy and done tell the controller when the link is free again.

Top module: `gclk_gen`

## Requirements
- R1: While chip select (`cs_n`) is high, `sclk` is low and does not toggle. After reset and while idle, `cs_n`=1, `sclk`=0, `busy`=0 and `done`=0.
- R2: The device clock half-period is (D+1) system clocks, where D is the active divider value. Successive rising edges are 2(D+1) cycles apart.
- R3: A `start` pulse sampled while `busy` is low is accepted. At that edge `cs_n` goes low and `busy` goes high. The first rising edge of `sclk` follows 2(D+1) cycles later.
- R4: A request with bit count N>0 produces exactly N rising and N falling `sclk` edges. `rise_stb` is high for exactly the cycles in which `sclk` has just gone high, and `fall_stb` for exactly the cycles in which it has just gone low.
- R5: `cs_n` rises 4(D+1) cycles after the last falling edge, which is (5+2N)(D+1) cycles after acceptance. `done` is high for exactly that one cycle, and `busy` drops in that same cycle.
- R6: A divider write while idle takes effect for the next accepted request. A write during a transaction leaves the running transaction unchanged and takes effect once `cs_n` is high again; the last such write wins.
- R7: A `start` pulse while `busy` is high is ignored. Its bit count does not change the running transaction.
- R8: A request with N=0 gives no `sclk` edge and holds `cs_n` low for 5(D+1) cycles.
- R9: Synchronous reset during a transaction returns `cs_n` high, `sclk` low, `busy` low and `done` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr | input | 1 | Divider write strobe |
| div_val | input | DIV_W | Divider value D; half-period is D+1 cycles |
| start | input | 1 | Transaction request pulse |
| nbits | input | CNT_W | Number of bits in the requested transaction |
| busy | output | 1 | High from acceptance until chip select rises |
| done | output | 1 | One-cycle pulse when chip select rises |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Device clock, idle low |
| rise_stb | output | 1 | Pulse with each rising edge of sclk |
| fall_stb | output | 1 | Pulse with each falling edge of sclk |

## Verification
The hardest case to reach is a divider write that lands while a transaction is running. It must be held back and then picked up only after chip select returns high. The bench drives such a write partway through a transfer and times every edge of that transfer against the old half-period. It then starts another transfer without any further write and times it against the deferred value. A start pulse with a different bit count is injected mid-transfer in the same way, and the edge counts confirm that it was dropped.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_TAIL = 2'd3
    } gclk_state_e;
endpackage

// File: rtl/gclk_div.sv
// Half-period tick source with deferred divider update.
module gclk_div #(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             wr,
    input  logic [DIV_W-1:0] wr_val,
    output logic             tick,
    output logic [DIV_W-1:0] div_act
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] pend;
        logic             pend_vld;
    } div_st_t;

    localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(DIV_RST);

    div_st_t q, d;

    always_comb begin
        d = q;
        if (idle) begin
            d.cnt = '0;
            if (wr) begin
                d.act      = wr_val;
                d.pend_vld = 1'b0;
            end else if (q.pend_vld) begin
                d.act      = q.pend;
                d.pend_vld = 1'b0;
            end
        end else begin
            if (q.cnt == q.act) d.cnt = '0;
            else                d.cnt = q.cnt + 1'b1;
            if (wr) begin
                d.pend     = wr_val;
                d.pend_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.cnt      <= '0;
            q.act      <= RST_VAL;
            q.pend     <= '0;
            q.pend_vld <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign tick    = !idle && (q.cnt == q.act);
    assign div_act = q.act;

    // R6: the active rate is frozen whenever a transaction is in flight
    p_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(q.act));
    // R2: the half-period counter never passes the active divider
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        q.cnt <= q.act);
endmodule

// File: rtl/gclk_bitcnt.sv
// Remaining-bit counter for the running transaction.
module gclk_bitcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] left
);
    logic [CNT_W-1:0] left_q, left_d;

    always_comb begin
        left_d = left_q;
        if (load)     left_d = load_val;
        else if (dec) left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) left_q <= '0;
        else     left_q <= left_d;
    end

    assign left = left_q;

    // R4: a bit is never retired when none remain
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        dec |-> left_q != '0);
endmodule

// File: rtl/gclk_gen.sv
// Gated serial device clock with chip-select framing.
module gclk_gen #(
    parameter int DIV_W   = 8,
    parameter int CNT_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic             start,
    input  logic [CNT_W-1:0] nbits,
    output logic             busy,
    output logic             done,
    output logic             cs_n,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    import gclk_pkg::*;

    localparam int TAIL_TICKS = 4;
    localparam int PH_W       = $clog2(TAIL_TICKS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TAIL_TICKS - 1);

    typedef struct packed {
        gclk_state_e      state;
        logic [PH_W-1:0]  ph;
        logic             cs_n;
        logic             sclk;
        logic             rise;
        logic             fall;
        logic             done;
        logic             busy;
    } seq_st_t;

    seq_st_t q, d;

    logic             tick;
    logic [DIV_W-1:0] div_act;
    logic [CNT_W-1:0] left;
    logic             accept;
    logic             bit_dec;

    assign accept  = (q.state == ST_IDLE) && start;
    assign bit_dec = tick && (q.state == ST_RUN) && q.sclk;

    gclk_div #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_div (
        .clk     (clk),
        .rst     (rst),
        .idle    (q.state == ST_IDLE),
        .wr      (div_wr),
        .wr_val  (div_val),
        .tick    (tick),
        .div_act (div_act)
    );

    gclk_bitcnt #(.CNT_W(CNT_W)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (nbits),
        .dec      (bit_dec),
        .left     (left)
    );

    always_comb begin
        d      = q;
        d.rise = 1'b0;
        d.fall = 1'b0;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.state = ST_LEAD;
                    d.cs_n  = 1'b0;
                    d.busy  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    d.state = (left == '0) ? ST_TAIL : ST_RUN;
                    d.ph    = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                        d.rise = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        d.fall = 1'b1;
                        if (left == CNT_W'(1)) begin
                            d.state = ST_TAIL;
                            d.ph    = '0;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    if (q.ph == PH_LAST) begin
                        d.state = ST_IDLE;
                        d.cs_n  = 1'b1;
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= ST_IDLE;
            q.ph    <= '0;
            q.cs_n  <= 1'b1;
            q.sclk  <= 1'b0;
            q.rise  <= 1'b0;
            q.fall  <= 1'b0;
            q.done  <= 1'b0;
            q.busy  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign cs_n     = q.cs_n;
    assign sclk     = q.sclk;
    assign rise_stb = q.rise;
    assign fall_stb = q.fall;

    // R1: clock is parked low whenever chip select is released
    p_clk_parked_r1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);
    // R4: strobes coincide with the clock edges they announce
    p_rise_edge_r4: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> (sclk && !$past(sclk)));
    p_fall_edge_r4: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> (!sclk && $past(sclk)));
    p_edge_strobed_r4: assert property (@(posedge clk) disable iff (rst)
        (sclk != $past(sclk)) |-> (rise_stb || fall_stb));
    // R5: done is a single pulse at chip-select release, busy already low
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_frame_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !busy));
    // R3: chip select falls only together with busy rising
    p_cs_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $rose(busy));
endmodule

// File: tb/gclk_gen_tb.sv
module gclk_gen_tb;
    localparam int DW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          div_wr = 1'b0;
    logic [DW-1:0] div_val = '0;
    logic          start = 1'b0;
    logic [CW-1:0] nbits = '0;
    logic busy, done, cs_n, sclk, rise_stb, fall_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    gclk_gen #(.DIV_W(DW), .CNT_W(CW), .DIV_RST(3)) u_dut (
        .clk(clk), .rst(rst), .div_wr(div_wr), .div_val(div_val),
        .start(start), .nbits(nbits), .busy(busy), .done(done),
        .cs_n(cs_n), .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic set_div(input int v);
        @(negedge clk);
        div_wr  = 1'b1;
        div_val = DW'(v);
        @(negedge clk);
        div_wr  = 1'b0;
    endtask

    // One transfer; h = expected half-period in system cycles.
    // wr_k / st_k: sample index at which to inject a divider write / a start.
    task automatic xfer(input int h, input int n, input int wr_k, input int wr_v,
                        input int st_k, input int st_n, input string tag);
        int k = 0;
        int rises = 0;
        int falls = 0;
        int last_fall = -1;
        int strobe_bad = 0;
        int busy_bad = 0;
        int cs_rise = -1;
        bit prev = 1'b0;
        @(negedge clk);
        start = 1'b1;
        nbits = CW'(n);
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0 && busy == 1'b1, {"R3 accept ", tag}, {cs_n, busy}, 1);
        while (k < 20000) begin
            if (k > 0) begin
                if (rise_stb != (sclk && !prev)) strobe_bad++;
                if (fall_stb != (!sclk && prev)) strobe_bad++;
                if (sclk && !prev) begin
                    chk(k == (2 + 2 * rises) * h, {"R2/R3 rise time ", tag}, k, (2 + 2 * rises) * h);
                    rises++;
                end
                if (!sclk && prev) begin
                    chk(k == (3 + 2 * falls) * h, {"R2 fall time ", tag}, k, (3 + 2 * falls) * h);
                    falls++;
                    last_fall = k;
                end
                if (cs_n) begin
                    cs_rise = k;
                    break;
                end
                if (!busy || done) busy_bad++;
            end
            prev = sclk;
            div_wr = (k == wr_k);
            if (k == wr_k) div_val = DW'(wr_v);
            start = (k == st_k);
            if (k == st_k) nbits = CW'(st_n);
            @(negedge clk);
            k++;
        end
        div_wr = 1'b0;
        start  = 1'b0;
        chk(rises == n, {"R4 rise count ", tag}, rises, n);
        chk(falls == n, {"R4 fall count ", tag}, falls, n);
        chk(strobe_bad == 0, {"R4 strobes ", tag}, strobe_bad, 0);
        chk(busy_bad == 0, {"R5 busy held ", tag}, busy_bad, 0);
        chk(cs_rise == (5 + 2 * n) * h, {"R5 cs release ", tag}, cs_rise, (5 + 2 * n) * h);
        if (n > 0)
            chk(cs_rise - last_fall == 4 * h, {"R5 tail gap ", tag}, cs_rise - last_fall, 4 * h);
        chk(done == 1'b1 && busy == 1'b0 && sclk == 1'b0, {"R5 done pulse ", tag},
            {done, busy, sclk}, 3'b100);
        @(negedge clk);
        chk(done == 1'b0 && cs_n == 1'b1, {"R5 done width ", tag}, {done, cs_n}, 2'b01);
    endtask

    task automatic t_reset_state();
        chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
            "R1 reset state", {cs_n, sclk, busy, done}, 4'b1000);
    endtask

    task automatic t_idle_quiet();
        int bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk || !cs_n || rise_stb || fall_stb || busy) bad++;
        end
        chk(bad == 0, "R1 idle no toggle", bad, 0);
    endtask

    task automatic t_basic();
        set_div(0);
        xfer(1, 3, -1, 0, -1, 0, "div0 n3");
        set_div(2);
        xfer(3, 2, -1, 0, -1, 0, "div2 n2");
    endtask

    task automatic t_slow_then_fast();
        set_div(6);
        xfer(7, 1, -1, 0, -1, 0, "R6 slow");
        set_div(1);
        xfer(2, 4, -1, 0, -1, 0, "R6 fast");
    endtask

    task automatic t_deferred_write();
        set_div(1);
        xfer(2, 4, 5, 4, -1, 0, "R6 write mid");
        xfer(5, 2, -1, 0, -1, 0, "R6 deferred applied");
    endtask

    task automatic t_start_busy();
        set_div(2);
        xfer(3, 3, -1, 0, 7, 9, "R7 start ignored");
    endtask

    task automatic t_zero_bits();
        set_div(1);
        xfer(2, 0, -1, 0, -1, 0, "R8 zero bits");
    endtask

    task automatic t_reset_mid();
        set_div(3);
        @(negedge clk);
        start = 1'b1;
        nbits = CW'(5);
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0,
            "R9 reset mid", {cs_n, sclk, busy, done}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        set_div(0);
        xfer(1, 2, -1, 0, -1, 0, "R9 after reset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_idle_quiet();
        t_basic();
        t_slow_then_fast();
        t_deferred_write();
        t_start_busy();
        t_zero_bits();
        t_reset_mid();
        t_idle_quiet();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end
endmodule